// File: doc/BRIEF.md
# Sprite XOR Blitter with Collision Detect

The blitter draws a sprite that is eight pixels wide and up to fifteen rows tall into a 64x32 monochrome framebuffer of 256 bytes. Each framebuffer row is eight bytes, and the most significant bit of a byte is its leftmost pixel. A command gives an X and a Y coordinate, a row count and a sprite base address. The block reads the sprite rows from a byte-wide memory port. It moves each row to the requested pixel position and XORs it into the framebuffer. While it does so it notes whether any pixel that was lit has been turned off.

The operation has two phases. First every sprite row is read and pre-shifted into an internal row store. The block then parks until the display reports a blanking interval. Only after that does it walk the framebuffer with read-modify-write cycles. Sprites clip at the right edge and at the bottom edge and never wrap. When the work ends the block gives a one-cycle done pulse, with a collision flag that is valid in the same cycle.

The memory ports are plain request ports, not streams. A read issued in one cycle returns its data in the next cycle. There is no back-pressure: every request is served.

Top module: `sprite_blitter`

## Requirements
- R1: The first framebuffer byte touched is (Y mod 32)*8 + ((X mod 64) >> 3). Coordinate bits above those ranges have no effect.
- R2: Let s = X mod 8. Each sprite byte b splits into a left part b >> s and a right part, which holds the bits shifted out of b, placed MSB-first. The left part goes to the target byte and the right part goes to the byte at the next address. When s = 0 the right part is zero.
- R3: Each part is merged as new = old XOR part, and the other bits of the framebuffer are not changed.
- R4: The collision output is 1 when any part ANDed with the old byte it lands on is nonzero, and 0 otherwise. It is valid in the cycle where done is high.
- R5: When the target byte is in column 7 of its row (address bits [2:0] = 7), the right part is dropped. The byte at the next address is not accessed.
- R6: After each row the target address advances by 8. When that sum passes 255, the remaining rows are not drawn, so nothing wraps to the top.
- R7: A row count of 0 causes no framebuffer access. The block still waits for blanking, then gives done with collision = 0.
- R8: Sprite rows are read at addresses base, base+1, ... base+N-1, all of them before any framebuffer access. Framebuffer access starts only after blank is seen high at a clock edge once all sprite reads are done. A blank pulse during the sprite reads is ignored.
- R9: Each framebuffer byte is updated by a read in one cycle, followed in the next cycle by a write to the same address. Read data returns one cycle after the read.
- R10: A start pulse while busy is ignored. Done is high for exactly one cycle per accepted command, and busy is low in the following cycle.
- R11: After reset, busy and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe, accepted when idle |
| pos_x | input | 8 | X pixel coordinate, used modulo 64 |
| pos_y | input | 8 | Y pixel coordinate, used modulo 32 |
| rows | input | 4 | Sprite row count N |
| sprite_base | input | SPR_AW | Address of the first sprite byte |
| blank | input | 1 | Blanking strobe from the display |
| spr_rd | output | 1 | Sprite memory read request |
| spr_addr | output | SPR_AW | Sprite memory address |
| spr_data | input | 8 | Sprite read data, one cycle after spr_rd |
| fb_rd | output | 1 | Framebuffer read request |
| fb_wr | output | 1 | Framebuffer write request |
| fb_addr | output | FB_AW | Framebuffer byte address |
| fb_wdata | output | 8 | Framebuffer write data |
| fb_rdata | input | 8 | Framebuffer read data, one cycle after fb_rd |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| collision | output | 1 | Pixel-erase flag, valid with done |

## Verification
The first sprite is drawn byte-aligned on an empty framebuffer, which tests addressing and merging with no collision. Drawing the same sprite again at the same place must clear it and raise the collision flag. An unaligned X tests the two-byte split. Column-7 and bottom-row positions test right and bottom clipping against any wrap, and coordinates above 63 and 31 test the modulo rule. Further runs use a zero row count, a blank pulse sent during the sprite reads, and a second start sent while busy. These tell the ordering and ignore rules apart from plain drawing: on each clock, framebuffer traffic before the real blank, or a write without its matching read, is recorded.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_FREQ,
    S_FCAP,
    S_WAIT,
    S_RDL,
    S_WRL,
    S_RDR,
    S_WRR,
    S_DONE
  } blit_state_e;
endpackage

// File: rtl/blit_split.sv
module blit_split (
  input  logic [7:0]  pix,
  input  logic [2:0]  sh,
  output logic [15:0] pair
);
  // upper byte: part for the target byte, lower byte: bits that spill right
  assign pair = {pix, 8'h00} >> sh;
endmodule

// File: rtl/blit_rowbuf.sv
module blit_rowbuf #(
  parameter int IDX_W = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (we && widx == IDX_W'(g)) ent[g] <= wdata;
    end
  end

  assign rdata = ent[ridx];
endmodule

// File: rtl/sprite_blitter.sv
module sprite_blitter #(
  parameter int SPR_AW  = 12,
  parameter int CNT_W   = 4,
  parameter int COLS_LG = 3,
  parameter int ROWS_LG = 5,
  localparam int FB_AW  = COLS_LG + ROWS_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        pos_x,
  input  logic [7:0]        pos_y,
  input  logic [CNT_W-1:0]  rows,
  input  logic [SPR_AW-1:0] sprite_base,
  input  logic              blank,
  output logic              spr_rd,
  output logic [SPR_AW-1:0] spr_addr,
  input  logic [7:0]        spr_data,
  output logic              fb_rd,
  output logic              fb_wr,
  output logic [FB_AW-1:0]  fb_addr,
  output logic [7:0]        fb_wdata,
  input  logic [7:0]        fb_rdata,
  output logic              busy,
  output logic              done,
  output logic              collision
);
  import blit_pkg::*;

  localparam int XW   = COLS_LG + 3;
  localparam int STEP = 1 << COLS_LG;

  blit_state_e       st_q;
  logic [2:0]        sh_q;
  logic [FB_AW-1:0]  tgt_q;
  logic [CNT_W-1:0]  nrow_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SPR_AW-1:0] base_q;
  logic              coll_q;

  logic [15:0]       split_pair;
  logic [15:0]       row_pair;
  logic [FB_AW:0]    tgt_nx;
  logic              last_row;
  logic              last_col;
  logic [7:0]        part;
  logic              unused_bits;

  assign unused_bits = ^{pos_x[7:XW], pos_y[7:ROWS_LG]};

  blit_split u_split (
    .pix  (spr_data),
    .sh   (sh_q),
    .pair (split_pair)
  );

  blit_rowbuf #(.IDX_W(CNT_W), .DW(16)) u_rowbuf (
    .clk   (clk),
    .we    (st_q == S_FCAP),
    .widx  (cnt_q),
    .wdata (split_pair),
    .ridx  (cnt_q),
    .rdata (row_pair)
  );

  assign tgt_nx   = {1'b0, tgt_q} + (FB_AW+1)'(STEP);
  assign last_row = (cnt_q + 1'b1 == nrow_q) || tgt_nx[FB_AW];
  assign last_col = &tgt_q[COLS_LG-1:0];
  assign part     = (st_q == S_WRR) ? row_pair[7:0] : row_pair[15:8];

  always_comb begin
    spr_rd   = (st_q == S_FREQ);
    spr_addr = base_q + SPR_AW'(cnt_q);
    fb_rd    = (st_q == S_RDL) || (st_q == S_RDR);
    fb_wr    = (st_q == S_WRL) || (st_q == S_WRR);
    fb_addr  = (st_q == S_RDR || st_q == S_WRR) ? tgt_q + FB_AW'(1) : tgt_q;
    fb_wdata = fb_rdata ^ part;
  end

  assign busy      = (st_q != S_IDLE);
  assign done      = (st_q == S_DONE);
  assign collision = coll_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      sh_q   <= '0;
      tgt_q  <= '0;
      nrow_q <= '0;
      cnt_q  <= '0;
      base_q <= '0;
      coll_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start) begin
          sh_q   <= pos_x[2:0];
          tgt_q  <= {pos_y[ROWS_LG-1:0], pos_x[XW-1:3]};
          nrow_q <= rows;
          base_q <= sprite_base;
          cnt_q  <= '0;
          coll_q <= 1'b0;
          st_q   <= (rows == '0) ? S_WAIT : S_FREQ;
        end
        S_FREQ: st_q <= S_FCAP;
        S_FCAP: begin
          if (cnt_q + 1'b1 == nrow_q) begin
            cnt_q <= '0;
            st_q  <= S_WAIT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            st_q  <= S_FREQ;
          end
        end
        S_WAIT: if (blank) st_q <= (nrow_q == '0) ? S_DONE : S_RDL;
        S_RDL:  st_q <= S_WRL;
        S_RDR:  st_q <= S_WRR;
        S_WRL, S_WRR: begin
          if (|(fb_rdata & part)) coll_q <= 1'b1;
          if (st_q == S_WRL && !last_col) begin
            st_q <= S_RDR;
          end else if (last_row) begin
            st_q <= S_DONE;
          end else begin
            tgt_q <= tgt_nx[FB_AW-1:0];
            cnt_q <= cnt_q + 1'b1;
            st_q  <= S_RDL;
          end
        end
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  logic [SPR_AW-1:0] spr_ofs;
  assign spr_ofs = spr_addr - base_q;

  AST_RMW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    fb_wr |-> ($past(fb_rd) && fb_addr == $past(fb_addr)));  // R9

  AST_SPR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    spr_rd |-> (spr_ofs < SPR_AW'(nrow_q)));  // R8

  AST_RIGHT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rd && st_q == S_RDR) |-> (fb_addr[COLS_LG-1:0] != '0));  // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));  // R10

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);  // R10
endmodule

// File: tb/test_sprite_blitter.sv
module test_sprite_blitter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  pos_x = '0;
  logic [7:0]  pos_y = '0;
  logic [3:0]  rows = '0;
  logic [11:0] sprite_base = '0;
  logic        blank = 1'b0;
  logic        spr_rd;
  logic [11:0] spr_addr;
  logic [7:0]  spr_data;
  logic        fb_rd, fb_wr;
  logic [7:0]  fb_addr, fb_wdata, fb_rdata;
  logic        busy, done, collision;

  always #(CLK_PERIOD/2) clk = ~clk;

  sprite_blitter i_sprite_blitter (
    .clk(clk), .rst_n(rst_n), .start(start), .pos_x(pos_x), .pos_y(pos_y),
    .rows(rows), .sprite_base(sprite_base), .blank(blank),
    .spr_rd(spr_rd), .spr_addr(spr_addr), .spr_data(spr_data),
    .fb_rd(fb_rd), .fb_wr(fb_wr), .fb_addr(fb_addr), .fb_wdata(fb_wdata),
    .fb_rdata(fb_rdata), .busy(busy), .done(done), .collision(collision)
  );

  logic [7:0] fbm [256];
  logic [7:0] spm [4096];
  int ref_fb [256];
  int ref_coll;

  always @(posedge clk) begin
    if (fb_rd) fb_rdata <= fbm[fb_addr];
    if (fb_wr) fbm[fb_addr] <= fb_wdata;
    if (spr_rd) spr_data <= spm[spr_addr];
  end

  int tests = 0, fails = 0;
  int viol_ord = 0, viol_rmw = 0, done_cnt = 0, fb_acc = 0;
  bit blank_ok = 0;
  logic prev_rd = 0;
  logic [7:0] prev_addr = '0;

  // per-clock monitor of port traffic against the ordering rules
  always @(negedge clk) begin
    if (rst_n) begin
      if ((fb_rd || fb_wr) && !blank_ok) viol_ord++;
      if (spr_rd && blank_ok) viol_ord++;
      if (fb_wr && !(prev_rd && prev_addr == fb_addr)) viol_rmw++;
      if (fb_rd || fb_wr) fb_acc++;
      if (done) done_cnt++;
      prev_rd = fb_rd;
      prev_addr = fb_addr;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ref_draw(input int x, input int y, input int n, input int base);
    int xs = x % 64, ys = y % 32;
    int s = xs % 8;
    int a = ys * 8 + xs / 8;
    ref_coll = 0;
    for (int r = 0; r < n; r++) begin
      int w, lp, rp;
      if (a > 255) break;
      w = (int'(spm[(base + r) % 4096]) << 8) >> s;
      lp = (w >> 8) & 255;
      rp = w & 255;
      if ((ref_fb[a] & lp) != 0) ref_coll = 1;
      ref_fb[a] = ref_fb[a] ^ lp;
      if (a % 8 != 7) begin
        if ((ref_fb[a+1] & rp) != 0) ref_coll = 1;
        ref_fb[a+1] = ref_fb[a+1] ^ rp;
      end
      a += 8;
    end
  endtask

  task automatic run_op(input int x, input int y, input int n, input int base,
                        input bit early_blank, input bit intrude, input string req);
    int bad = 0;
    int got_coll = -1;
    bit seen = 0;
    ref_draw(x, y, n, base);
    viol_ord = 0; viol_rmw = 0; done_cnt = 0; fb_acc = 0; blank_ok = 0;
    @(negedge clk);
    pos_x = 8'(x); pos_y = 8'(y); rows = 4'(n); sprite_base = 12'(base); start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    if (early_blank) blank = 1;
    @(negedge clk);
    blank = 0;
    if (intrude) begin
      pos_x = 8'(x + 9); pos_y = 8'(y + 3); rows = 4'd2; sprite_base = 12'(base + 40);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    repeat (45) @(negedge clk);
    blank_ok = 1; blank = 1;
    @(negedge clk);
    blank = 0;
    for (int c = 0; c < 300; c++) begin
      if (done && !seen) begin seen = 1; got_coll = int'(collision); end
      @(negedge clk);
    end
    check(seen, {req, " done seen (R10)"}, int'(seen), 1);
    check(got_coll == ref_coll, {req, " collision (R4)"}, got_coll, ref_coll);
    check(done_cnt == 1, {req, " single done pulse (R10)"}, done_cnt, 1);
    check(viol_ord == 0, {req, " blank/fetch ordering (R8)"}, viol_ord, 0);
    check(viol_rmw == 0, {req, " read-then-write (R9)"}, viol_rmw, 0);
    for (int i = 0; i < 256; i++) if (int'(fbm[i]) != ref_fb[i]) bad++;
    check(bad == 0, {req, " framebuffer bytes (R1 R2 R3)"}, bad, 0);
  endtask

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) spm[i] = 8'((i * 37 + 11) ^ (i >> 3));
    spm[100] = 8'hFF; spm[101] = 8'h81; spm[102] = 8'hC3;
    for (int i = 0; i < 256; i++) begin fbm[i] = '0; ref_fb[i] = 0; end
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0, "R11 reset outputs", int'({busy, done}), 0);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0, "R11 idle after reset", int'(busy), 0);

    run_op(0, 0, 3, 100, 0, 0, "R1 aligned draw");
    run_op(0, 0, 3, 100, 0, 0, "R4 redraw erases");
    check(ref_coll == 1 && fbm[0] == 8'h00, "R4 R3 erase result", int'(fbm[0]), 0);
    run_op(13, 5, 4, 200, 0, 0, "R2 unaligned split");
    run_op(14, 5, 4, 300, 0, 0, "R4 overlapping shifted");
    // column 7: right part must not reach the next row's first byte
    run_op(60, 2, 2, 100, 0, 0, "R5 column 7 clip");
    check(fbm[24] == 8'(ref_fb[24]) && fbm[32] == 8'(ref_fb[32]),
          "R5 next byte untouched", int'(fbm[24]), ref_fb[24]);
    // bottom: only two rows fit
    run_op(8, 30, 5, 400, 0, 0, "R6 bottom clip");
    check(fbm[1] == 8'(ref_fb[1]) && fbm[9] == 8'(ref_fb[9]),
          "R6 no wrap to top", int'(fbm[9]), ref_fb[9]);
    run_op(200, 40, 3, 500, 0, 0, "R1 coordinate modulo");
    run_op(17, 9, 0, 100, 0, 0, "R7 zero rows");
    check(fb_acc == 0 && collision == 0, "R7 no access, flag 0", fb_acc, 0);
    run_op(33, 12, 8, 600, 1, 0, "R8 early blank ignored");
    run_op(5, 20, 6, 700, 0, 1, "R10 start while busy");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule